// File: doc/BRIEF.md
# Three-Master Priority Bus Arbiter

This block decides which of three bus masters owns a shared bus: an Ethernet engine, a DMA engine and the CPU. Each master raises a request line. The owner marks the clock in which its current bus cycle finishes with a pulse on its own end-of-cycle line. The arbiter drives a one-hot grant vector. A new owner is chosen only at a cycle boundary, or on any clock while the bus sits idle.

Three configuration inputs shape the decision. The order bit picks one of two fixed rankings. The assume bit keeps the current owner in the contest as if it were still requesting. This costs one idle clock when an owner that outranks the others turns out to have nothing more to do. The lock bit freezes ownership on the current owner. When nobody requests, the grant stays parked on the last owner, so that owner can start its next cycle with no arbitration delay.

Top module: `arbx_bus_arbiter`

## Requirements
- R1: While reset is high, and on the first clock after it, no grant bit is set.
- R2: The grant vector is one-hot or zero at all times. Bit 0 is Ethernet, bit 1 is DMA and bit 2 is CPU.
- R3: With the order bit at 0, a contest is won by Ethernet first, then DMA, then CPU.
- R4: With the order bit at 1, a contest is won by CPU first, then DMA, then Ethernet.
- R5: A master that is granted while requesting owns a cycle in progress. Until the clock in which its end input is high, the grant holds whatever the requests or the configuration do. The new grant appears on the clock after that end pulse.
- R6: With the assume bit at 0, the owner at its end pulse competes only if its request is high. Otherwise the highest requester takes the bus on the next clock.
- R7: With the assume bit at 1, an owner that outranks every requester but has its request low at its end pulse keeps the grant for one idle clock. The bus then passes to the highest real requester on the clock after that.
- R8: With the lock bit at 1 and an owner present, the grant never changes, through any number of end pulses and requests.
- R9: When no master requests at an arbitration point, the grant stays on the last owner. While parked, a new request is granted on the next clock.
- R10: A change to the order or lock bit made during a cycle in progress does not move the grant before that cycle's end pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 3 | Request per master (bit 0 Ethernet, 1 DMA, 2 CPU) |
| end_i | input | 3 | End-of-cycle pulse per master, same bit order |
| cfg_order_i | input | 1 | Ranking select: 0 Ethernet first, 1 CPU first |
| cfg_assume_i | input | 1 | Keep current owner in the contest as if requesting |
| cfg_lock_i | input | 1 | Freeze ownership on the current owner |
| gnt_o | output | 3 | One-hot grant, same bit order |

## Verification
The hardest case to reach is the idle handover clock. It needs the assume bit set, an owner that outranks the waiting master under the current order, and that owner dropping its request in the same clock as its end pulse. A directed sequence first hands the bus to the CPU under CPU-first order. It then ends that cycle with only Ethernet waiting, and checks both the held clock and the handover clock. A long pseudo-random phase then mixes requests, end pulses and rare configuration flips. Each clock is compared against a behavioural model, so mid-cycle configuration changes and lock released while parked are also covered.

// File: rtl/arbx_pkg.sv
package arbx_pkg;
   // Bit positions of the masters in every request, end and grant vector.
   localparam int unsigned MST_ETH = 0;
   localparam int unsigned MST_DMA = 1;
   localparam int unsigned MST_CPU = 2;

   // Ranking select encoding.
   typedef enum logic {
      ORDER_LOW_FIRST  = 1'b0,
      ORDER_HIGH_FIRST = 1'b1
   } order_e;

   // Outcome of one arbitration point.
   typedef enum logic [1:0] {
      DEC_HOLD  = 2'd0,
      DEC_PARK  = 2'd1,
      DEC_IDLE  = 2'd2,
      DEC_GRANT = 2'd3
   } decision_e;
endpackage

// File: rtl/arbx_pick.sv
module arbx_pick #(
   parameter int unsigned NM = 3
) (
   input  logic [NM-1:0] cand,
   input  logic          order_hi,
   output logic [NM-1:0] win,
   output logic          any
);
   localparam logic [NM-1:0] ONE = NM'(1);

   logic [NM-1:0] lo_win;
   logic [NM-1:0] rev_cand;
   logic [NM-1:0] rev_win;
   logic [NM-1:0] hi_win;

   // Lowest set bit wins for the low-first ranking.
   assign lo_win = cand & (~cand + ONE);

   // High-first ranking: mirror, take lowest, mirror back.
   for (genvar i = 0; i < NM; i++) begin : g_mirror
      assign rev_cand[i] = cand[NM-1-i];
      assign hi_win[i]   = rev_win[NM-1-i];
   end
   assign rev_win = rev_cand & (~rev_cand + ONE);

   assign win = order_hi ? hi_win : lo_win;
   assign any = |cand;
endmodule

// File: rtl/arbx_ctrl.sv
module arbx_ctrl
   import arbx_pkg::*;
#(
   parameter int unsigned NM = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [NM-1:0] req,
   input  logic [NM-1:0] cyc_end,
   input  logic          cfg_assume,
   input  logic          cfg_lock,
   input  logic [NM-1:0] win,
   input  logic          win_any,
   output logic [NM-1:0] cand,
   output logic [NM-1:0] gnt
);
   logic [NM-1:0] gnt_q, gnt_d;
   logic          busy_q, busy_d;
   logic          skip_q, skip_d;
   logic          have_owner, own_req, own_end, arb_pt;
   decision_e     dec;

   assign have_owner = |gnt_q;
   assign own_req    = |(req & gnt_q);
   assign own_end    = |(cyc_end & gnt_q);
   assign arb_pt     = !busy_q || own_end;

   // Candidate set: real requests, plus the owner when it is assumed to stay.
   assign cand = req | ((cfg_assume && !skip_q) ? gnt_q : '0);

   always_comb begin
      if (!arb_pt)                    dec = DEC_HOLD;
      else if (cfg_lock && have_owner) dec = DEC_HOLD;
      else if (!win_any)              dec = DEC_PARK;
      else if (win == gnt_q && !own_req) dec = DEC_IDLE;
      else                            dec = DEC_GRANT;
   end

   always_comb begin
      gnt_d  = gnt_q;
      busy_d = busy_q;
      skip_d = skip_q;
      unique case (dec)
         DEC_HOLD: begin
            if (arb_pt) busy_d = own_req;
         end
         DEC_PARK: begin
            busy_d = 1'b0;
         end
         DEC_IDLE: begin
            busy_d = 1'b0;
            skip_d = 1'b1;
         end
         DEC_GRANT: begin
            gnt_d  = win;
            busy_d = 1'b1;
            skip_d = 1'b0;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         gnt_q  <= '0;
         busy_q <= 1'b0;
         skip_q <= 1'b0;
      end else begin
         gnt_q  <= gnt_d;
         busy_q <= busy_d;
         skip_q <= skip_d;
      end
   end

   assign gnt = gnt_q;
endmodule

// File: rtl/arbx_bus_arbiter.sv
module arbx_bus_arbiter
   import arbx_pkg::*;
#(
   parameter int unsigned NM = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [NM-1:0] req_i,
   input  logic [NM-1:0] end_i,
   input  logic          cfg_order_i,
   input  logic          cfg_assume_i,
   input  logic          cfg_lock_i,
   output logic [NM-1:0] gnt_o
);
   if (NM < 2) begin : g_bad_nm
      $error("arbx_bus_arbiter: NM must be at least 2");
   end
   if (NM <= MST_CPU) begin : g_bad_map
      $error("arbx_bus_arbiter: NM too small for the master map");
   end

   logic [NM-1:0] cand;
   logic [NM-1:0] win;
   logic          win_any;

   arbx_pick #(.NM(NM)) u_pick (
      .cand     (cand),
      .order_hi (cfg_order_i == ORDER_HIGH_FIRST),
      .win      (win),
      .any      (win_any)
   );

   arbx_ctrl #(.NM(NM)) u_ctrl (
      .clk        (clk),
      .rst        (rst),
      .req        (req_i),
      .cyc_end    (end_i),
      .cfg_assume (cfg_assume_i),
      .cfg_lock   (cfg_lock_i),
      .win        (win),
      .win_any    (win_any),
      .cand       (cand),
      .gnt        (gnt_o)
   );
endmodule

// File: rtl/arbx_chk.sv
module arbx_chk #(
   parameter int unsigned NM = 3
) (
   input logic          clk,
   input logic          rst,
   input logic [NM-1:0] req_i,
   input logic          cfg_order_i,
   input logic          cfg_lock_i,
   input logic [NM-1:0] gnt_o
);
   localparam logic [NM-1:0] ONE = NM'(1);

   logic          order_q;
   logic [NM-1:0] hi_mask;

   always_ff @(posedge clk) order_q <= cfg_order_i;

   // Masters that outrank the current grant under the order used for it.
   assign hi_mask = order_q ? ~(gnt_o | (gnt_o - ONE)) : (gnt_o - ONE);

   AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(gnt_o)); // R2

   AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (gnt_o == '0)); // R1

   AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (rst)
      (cfg_lock_i && gnt_o != '0) |=> (gnt_o == $past(gnt_o))); // R8

   AST_NEW_OWNER_REQ: assert property (@(posedge clk) disable iff (rst)
      (gnt_o != $past(gnt_o)) |-> (($past(req_i) & gnt_o) != '0)); // R6

   AST_NO_HIGHER_WAIT: assert property (@(posedge clk) disable iff (rst)
      (gnt_o != $past(gnt_o) && gnt_o != '0) |-> (($past(req_i) & hi_mask) == '0)); // R3
endmodule

bind arbx_bus_arbiter arbx_chk #(.NM(NM)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .req_i       (req_i),
   .cfg_order_i (cfg_order_i),
   .cfg_lock_i  (cfg_lock_i),
   .gnt_o       (gnt_o)
);

// File: tb/tb_arbx_bus_arbiter.sv
module tb_arbx_bus_arbiter;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] req = '0;
   logic [2:0] ends = '0;
   logic       order = 1'b0;
   logic       assume_r = 1'b0;
   logic       lock = 1'b0;
   logic [2:0] gnt;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit done = 0;
   string tag = "R1";

   // Behavioural reference state.
   int m_owner = -1;
   bit m_busy = 0;
   bit m_skip = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   arbx_bus_arbiter dut (
      .clk(clk), .rst(rst), .req_i(req), .end_i(ends),
      .cfg_order_i(order), .cfg_assume_i(assume_r), .cfg_lock_i(lock),
      .gnt_o(gnt)
   );

   function automatic int rank(int m, bit ord);
      return ord ? 2 - m : m;
   endfunction

   function automatic logic [2:0] exp_gnt();
      return (m_owner < 0) ? 3'b000 : 3'(1 << m_owner);
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_owner = -1; m_busy = 0; m_skip = 0;
      end else begin
         bit point;
         point = !m_busy || (m_owner >= 0 && ends[m_owner]);
         if (point) begin
            if (lock && m_owner >= 0) begin
               m_busy = req[m_owner];
            end else begin
               int best;
               best = -1;
               for (int m = 0; m < 3; m++) begin
                  bit elig;
                  elig = req[m] || (assume_r && !m_skip && m == m_owner);
                  if (elig && (best < 0 || rank(m, order) < rank(best, order)))
                     best = m;
               end
               if (best < 0) m_busy = 0;
               else if (best == m_owner && !req[m_owner]) begin
                  m_busy = 0; m_skip = 1;
               end else begin
                  m_owner = best; m_busy = 1; m_skip = 0;
               end
            end
         end
      end
   end

   // Model comparison on every clock, away from the active edge.
   always @(negedge clk) begin
      if (!rst && !done) begin
         total++;
         if (gnt !== exp_gnt()) begin
            bad++;
            $display("FAIL %s model compare: gnt=%b expected=%b", tag, gnt, exp_gnt());
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG && !done) begin
         done = 1;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic tick(int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic hard(logic [2:0] exp, string t);
      total++;
      if (gnt !== exp) begin
         bad++;
         $display("FAIL %s: gnt=%b expected=%b", t, gnt, exp);
      end
   endtask

   initial begin
      logic [15:0] lf;
      tick(3);
      hard(3'b000, "R1 during reset");
      rst = 1'b0;
      tick();
      hard(3'b000, "R1 after reset");

      // R3: Ethernet-first ranking.
      tag = "R3";
      req = 3'b111; tick();
      hard(3'b001, "R3 all request");
      req = 3'b110; ends = 3'b001; tick(); ends = '0;
      hard(3'b010, "R3 DMA next");

      // R10 then R4: order flip mid-cycle, effective at end pulse.
      tag = "R10";
      order = 1'b1; req = 3'b111; tick(2);
      hard(3'b010, "R10 order change mid-cycle");
      tag = "R4";
      ends = 3'b010; tick(); ends = '0;
      hard(3'b100, "R4 CPU first");

      // R6: assume off, owner drops request.
      tag = "R6";
      req = 3'b001; ends = 3'b100; tick(); ends = '0;
      hard(3'b001, "R6 release to Ethernet");

      // R7: assume on, dead clock on handover.
      tag = "R7";
      assume_r = 1'b1; req = 3'b100; ends = 3'b001; tick(); ends = '0;
      hard(3'b100, "R7 CPU wins");
      req = 3'b001; ends = 3'b100; tick(); ends = '0;
      hard(3'b100, "R7 idle clock");
      tick();
      hard(3'b001, "R7 handover");

      // R8: lock holds through end pulses.
      tag = "R8";
      assume_r = 1'b0; lock = 1'b1; req = 3'b111;
      ends = 3'b001; tick(); hard(3'b001, "R8 lock pulse 1");
      tick(); hard(3'b001, "R8 lock pulse 2");
      ends = '0; tick();
      tag = "R10";
      lock = 1'b0; tick(2);
      hard(3'b001, "R10 lock release mid-cycle");
      req = 3'b110; ends = 3'b001; tick(); ends = '0;
      hard(3'b100, "R10 release at end");

      // R9: parking.
      tag = "R9";
      req = 3'b000; ends = 3'b100; tick(); ends = '0;
      hard(3'b100, "R9 park");
      tick(3);
      hard(3'b100, "R9 still parked");
      req = 3'b010; tick();
      hard(3'b010, "R9 parked request");

      // R5: long pseudo-random run against the model.
      tag = "R5";
      lf = 16'hACE1;
      for (int k = 0; k < 4000; k++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         req  = lf[2:0];
         ends = lf[6:4] & {3{lf[9]}};
         if (lf[15:12] == 4'h0) order    = ~order;
         if (lf[15:12] == 4'h1) assume_r = ~assume_r;
         if (lf[15:12] == 4'h2 && lf[8]) lock = ~lock;
         tick();
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule